// File: doc/BRIEF.md
# Auto-indexed register port for a CD data controller

This block gives a host processor byte-wide access to the register file of a CD data controller through a single data port and a small index register. The host loads a 4-bit register index and then reads or writes the data port. Each access reaches the internal register that the index selects, and the index then steps forward by itself. A host can therefore sweep through a run of registers with back-to-back accesses after loading the index only once.

Reads and writes decode the same index differently. Writes reach the control side: interface control, the 16-bit byte counter, the data address, the write address and the block pointer, the two control bytes, and three command strobes. Reads reach the status side: interface status, the byte counter, a 4-byte sector header taken from one of two banks, the block pointer, the write address and the status bytes. Every 16-bit register is assembled from separately accessed low and high bytes. The header banks, the interface status and the status bytes are supplied by neighbouring logic. The written registers and the strobes are driven out to the transfer engine.

Top module: `cdc_regport`

## Requirements
- R1: After reset the index is 0, `rdata` is 0x00, every written register is 0x0000 or 0x00, both header banks hold zeros, and the interface status reads 0xFF.
- R2: A data read or write at a nonzero index moves the index to index+1 on the following edge, and index 15 moves to 0.
- R3: A data access while the index is 0 has no effect: the index stays 0, no register changes and `rdata` holds.
- R4: The write map, by index 1..15, is: interface control, counter low, counter high, data address low, data address high, transfer trigger, transfer acknowledge, write address low, write address high, control 0, control 1, pointer low, pointer high, spare control, reset command.
- R5: A low-byte write changes only bits 7:0 of its 16-bit register, and a high-byte write changes only bits 15:8.
- R6: The read map, by index 1..15, is: interface status, counter low, counter high, header bytes 0..3, pointer low, pointer high, write address low, write address high, status 0, status 1, status 2, status 3.
- R7: Status 1 (read index 13) always returns 0x00.
- R8: Header bytes are taken from bank 1 when bit 0 of control 1 is set and from bank 0 otherwise. Header byte 0 is bits 31:24 of the loaded 32-bit word.
- R9: Writes to index 6, 7 and 15 raise `trg_pulse`, `ack_pulse` and `rst_pulse` respectively for exactly one cycle, starting the cycle after the strobe. A write to index 14 changes nothing.
- R10: `idx_ld` loads `idx_din` into the index on the next edge. A data access in the same cycle is ignored. When both strobes are high, only the write takes place.
- R11: `rdata` is registered. It takes the selected value on the edge that ends a read strobe and otherwise holds.
- R12: `ifstat_ld` replaces the interface status with `ifstat_din`, and `hdr_ld` replaces the bank chosen by `hdr_bank` with `hdr_din`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| idx_ld | input | 1 | Load the register index |
| idx_din | input | 4 | New index value |
| idx | output | 4 | Current register index |
| rd_stb | input | 1 | Data port read strobe, one cycle per access |
| wr_stb | input | 1 | Data port write strobe, one cycle per access |
| wdata | input | 8 | Data port write byte |
| rdata | output | 8 | Registered data port read byte |
| hdr_ld | input | 1 | Load a header bank |
| hdr_bank | input | 1 | Header bank to load |
| hdr_din | input | 32 | Header word, byte 0 in bits 31:24 |
| ifstat_ld | input | 1 | Load interface status |
| ifstat_din | input | 8 | New interface status |
| stat0 | input | 8 | Status byte 0 |
| stat2 | input | 8 | Status byte 2 |
| stat3 | input | 8 | Status byte 3 |
| ifctrl | output | 8 | Interface control register |
| ctrl0 | output | 8 | Control 0 register |
| ctrl1 | output | 8 | Control 1 register |
| dbc | output | 16 | Byte counter |
| dac | output | 16 | Data address |
| wa | output | 16 | Write address |
| pt | output | 16 | Block pointer |
| trg_pulse | output | 1 | Transfer trigger strobe |
| ack_pulse | output | 1 | Transfer acknowledge strobe |
| rst_pulse | output | 1 | Reset command strobe |

## Verification
Every result of a strobe is due exactly one edge later: the index, the written registers, `rdata` and the command pulses all register on the edge that samples the strobe. The bench drives each strobe for one cycle from the falling edge. It compares all outputs with its own model at the next falling edge, then drops the strobes and checks at the following falling edge that the pulses have ended and `rdata` has held.

// File: rtl/cdc_regport.sv
module cdc_regport (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        idx_ld,
  input  logic [3:0]  idx_din,
  output logic [3:0]  idx,
  input  logic        rd_stb,
  input  logic        wr_stb,
  input  logic [7:0]  wdata,
  output logic [7:0]  rdata,
  input  logic        hdr_ld,
  input  logic        hdr_bank,
  input  logic [31:0] hdr_din,
  input  logic        ifstat_ld,
  input  logic [7:0]  ifstat_din,
  input  logic [7:0]  stat0,
  input  logic [7:0]  stat2,
  input  logic [7:0]  stat3,
  output logic [7:0]  ifctrl,
  output logic [7:0]  ctrl0,
  output logic [7:0]  ctrl1,
  output logic [15:0] dbc,
  output logic [15:0] dac,
  output logic [15:0] wa,
  output logic [15:0] pt,
  output logic        trg_pulse,
  output logic        ack_pulse,
  output logic        rst_pulse
);

  logic [7:0] ifstat;
  logic [7:0] hdr [2][4];
  logic       live, wr_go, rd_go;
  logic [7:0] rd_mux;

  assign live  = (idx != 4'd0) && !idx_ld;
  assign wr_go = live && wr_stb;
  assign rd_go = live && rd_stb && !wr_stb;

  always_ff @(posedge clk) begin
    if (!rst_n) idx <= 4'd0;
    else if (idx_ld) idx <= idx_din;
    else if (wr_go || rd_go) idx <= idx + 4'd1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ifctrl <= '0; ctrl0 <= '0; ctrl1 <= '0;
      dbc <= '0; dac <= '0; wa <= '0; pt <= '0;
    end else if (wr_go) begin
      case (idx)
        4'd1:  ifctrl     <= wdata;
        4'd2:  dbc[7:0]   <= wdata;
        4'd3:  dbc[15:8]  <= wdata;
        4'd4:  dac[7:0]   <= wdata;
        4'd5:  dac[15:8]  <= wdata;
        4'd8:  wa[7:0]    <= wdata;
        4'd9:  wa[15:8]   <= wdata;
        4'd10: ctrl0      <= wdata;
        4'd11: ctrl1      <= wdata;
        4'd12: pt[7:0]    <= wdata;
        4'd13: pt[15:8]   <= wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trg_pulse <= 1'b0; ack_pulse <= 1'b0; rst_pulse <= 1'b0;
    end else begin
      trg_pulse <= wr_go && (idx == 4'd6);
      ack_pulse <= wr_go && (idx == 4'd7);
      rst_pulse <= wr_go && (idx == 4'd15);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ifstat <= 8'hFF;
    else if (ifstat_ld) ifstat <= ifstat_din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < 2; b++)
        for (int k = 0; k < 4; k++) hdr[b][k] <= 8'h00;
    end else if (hdr_ld) begin
      for (int k = 0; k < 4; k++) hdr[hdr_bank][k] <= hdr_din[31-8*k -: 8];
    end
  end

  always_comb begin
    case (idx)
      4'd1:  rd_mux = ifstat;
      4'd2:  rd_mux = dbc[7:0];
      4'd3:  rd_mux = dbc[15:8];
      4'd4:  rd_mux = hdr[ctrl1[0]][0];
      4'd5:  rd_mux = hdr[ctrl1[0]][1];
      4'd6:  rd_mux = hdr[ctrl1[0]][2];
      4'd7:  rd_mux = hdr[ctrl1[0]][3];
      4'd8:  rd_mux = pt[7:0];
      4'd9:  rd_mux = pt[15:8];
      4'd10: rd_mux = wa[7:0];
      4'd11: rd_mux = wa[15:8];
      4'd12: rd_mux = stat0;
      4'd14: rd_mux = stat2;
      4'd15: rd_mux = stat3;
      default: rd_mux = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rdata <= 8'h00;
    else if (rd_go) rdata <= rd_mux;
  end

  p_idx_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_stb || wr_stb) && !idx_ld && idx != 4'd0) |=> idx == $past(idx) + 4'd1);

  p_idx_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!idx_ld && idx == 4'd0) |=> (idx == 4'd0 && $stable(rdata) && $stable(dbc)));

  p_low_lane_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !idx_ld && idx == 4'd2) |=> $stable(dbc[15:8]));

  p_stat1_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !wr_stb && !idx_ld && idx == 4'd13) |=> rdata == 8'h00);

  p_pulse_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({trg_pulse, ack_pulse, rst_pulse}));

  p_pulse_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
    trg_pulse |=> !trg_pulse);

  p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> $stable(rdata));

  p_idx_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    idx_ld |=> idx == $past(idx_din));

endmodule

// File: tb/cdc_regport_tb.sv
module cdc_regport_tb;
  logic clk = 0, rst_n = 0;
  logic idx_ld = 0, rd_stb = 0, wr_stb = 0, hdr_ld = 0, hdr_bank = 0, ifstat_ld = 0;
  logic [3:0] idx_din = 0, idx;
  logic [7:0] wdata = 0, rdata, ifstat_din = 0, stat0 = 8'h5A, stat2 = 8'hC3, stat3 = 8'h81;
  logic [31:0] hdr_din = 0;
  logic [7:0] ifctrl, ctrl0, ctrl1;
  logic [15:0] dbc, dac, wa, pt;
  logic trg_pulse, ack_pulse, rst_pulse;

  int checks = 0, errors = 0;

  logic [3:0] m_idx;
  logic [7:0] m_ifctrl, m_c0, m_c1, m_ifstat, m_rdata;
  logic [15:0] m_dbc, m_dac, m_wa, m_pt;
  logic [7:0] m_hdr [2][4];

  always #2 clk = ~clk;

  cdc_regport u_dut (.clk(clk), .rst_n(rst_n), .idx_ld(idx_ld), .idx_din(idx_din), .idx(idx),
    .rd_stb(rd_stb), .wr_stb(wr_stb), .wdata(wdata), .rdata(rdata),
    .hdr_ld(hdr_ld), .hdr_bank(hdr_bank), .hdr_din(hdr_din),
    .ifstat_ld(ifstat_ld), .ifstat_din(ifstat_din),
    .stat0(stat0), .stat2(stat2), .stat3(stat3),
    .ifctrl(ifctrl), .ctrl0(ctrl0), .ctrl1(ctrl1),
    .dbc(dbc), .dac(dac), .wa(wa), .pt(pt),
    .trg_pulse(trg_pulse), .ack_pulse(ack_pulse), .rst_pulse(rst_pulse));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(logic [3:0] i);
    case (i)
      1: return m_ifstat;
      2: return m_dbc[7:0];
      3: return m_dbc[15:8];
      4, 5, 6, 7: return m_hdr[m_c1[0]][i-4];
      8: return m_pt[7:0];
      9: return m_pt[15:8];
      10: return m_wa[7:0];
      11: return m_wa[15:8];
      12: return stat0;
      13: return 8'h00;
      14: return stat2;
      15: return stat3;
      default: return 8'h00;
    endcase
  endfunction

  task automatic model_reset();
    m_idx = 0; m_ifctrl = 0; m_c0 = 0; m_c1 = 0; m_ifstat = 8'hFF; m_rdata = 0;
    m_dbc = 0; m_dac = 0; m_wa = 0; m_pt = 0;
    for (int b = 0; b < 2; b++) for (int k = 0; k < 4; k++) m_hdr[b][k] = 0;
  endtask

  task automatic chk_regs(string tag);
    chk({tag, " R2 idx"}, idx, m_idx);
    chk({tag, " R4 ifctrl"}, ifctrl, m_ifctrl);
    chk({tag, " R4 ctrl0"}, ctrl0, m_c0);
    chk({tag, " R4 ctrl1"}, ctrl1, m_c1);
    chk({tag, " R5 dbc"}, dbc, m_dbc);
    chk({tag, " R5 dac"}, dac, m_dac);
    chk({tag, " R5 wa"}, wa, m_wa);
    chk({tag, " R5 pt"}, pt, m_pt);
    chk({tag, " R11 rdata"}, rdata, m_rdata);
  endtask

  task automatic finish_op(string tag, logic et, logic ea, logic er);
    @(negedge clk);
    chk_regs(tag);
    chk({tag, " R9 trg"}, trg_pulse, et);
    chk({tag, " R9 ack"}, ack_pulse, ea);
    chk({tag, " R9 rst"}, rst_pulse, er);
    idx_ld = 0; rd_stb = 0; wr_stb = 0; hdr_ld = 0; ifstat_ld = 0;
    @(negedge clk);
    chk({tag, " R9 pulse end"}, {trg_pulse, ack_pulse, rst_pulse}, 0);
    chk({tag, " R11 hold"}, rdata, m_rdata);
  endtask

  task automatic do_wr(logic [7:0] d);
    logic et, ea, er;
    et = 0; ea = 0; er = 0;
    wr_stb = 1; wdata = d;
    if (m_idx != 0) begin
      case (m_idx)
        1: m_ifctrl = d;
        2: m_dbc[7:0] = d;
        3: m_dbc[15:8] = d;
        4: m_dac[7:0] = d;
        5: m_dac[15:8] = d;
        6: et = 1;
        7: ea = 1;
        8: m_wa[7:0] = d;
        9: m_wa[15:8] = d;
        10: m_c0 = d;
        11: m_c1 = d;
        12: m_pt[7:0] = d;
        13: m_pt[15:8] = d;
        15: er = 1;
        default: ;
      endcase
      m_idx = m_idx + 1;
    end
    finish_op("wr", et, ea, er);
  endtask

  task automatic do_rd(logic with_wr);
    rd_stb = 1; wr_stb = with_wr; wdata = 8'h00;
    if (with_wr) begin
      do_wr(8'h00);
    end else begin
      if (m_idx != 0) begin
        m_rdata = exp_rd(m_idx);
        m_idx = m_idx + 1;
      end
      finish_op("rd R6", 0, 0, 0);
    end
  endtask

  task automatic do_ld(logic [3:0] v, logic with_acc);
    idx_ld = 1; idx_din = v; rd_stb = with_acc; wr_stb = with_acc; wdata = 8'hEE;
    m_idx = v;
    finish_op("ld R10", 0, 0, 0);
  endtask

  task automatic do_hdr(logic b, logic [31:0] w);
    hdr_ld = 1; hdr_bank = b; hdr_din = w;
    for (int k = 0; k < 4; k++) m_hdr[b][k] = w[31-8*k -: 8];
    finish_op("hdr R12", 0, 0, 0);
  endtask

  task automatic do_ifs(logic [7:0] v);
    ifstat_ld = 1; ifstat_din = v; m_ifstat = v;
    finish_op("ifs R12", 0, 0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk_regs("R1 reset");
    // R1 ifstat reset value readable
    do_ld(4'd1, 0); do_rd(0);
    chk("R1 ifstat", rdata, 8'hFF);
    // R3 access at index 0
    do_ld(4'd0, 0); do_wr(8'h77); do_rd(0);
    chk("R3 idx0", idx, 0);
    // R4/R5 write sweep
    do_ld(4'd1, 0);
    for (int i = 1; i <= 15; i++) do_wr(8'h10 + 8'(i));
    chk("R2 wrap", idx, 0);
    chk("R5 dbc", dbc, 16'h1312);
    chk("R5 dac", dac, 16'h1514);
    // R5 lane isolation
    do_ld(4'd3, 0); do_wr(8'hAB);
    chk("R5 high only", dbc, 16'hAB12);
    // R8 bank select
    do_hdr(0, 32'h01020304); do_hdr(1, 32'hA1B2C3D4);
    do_ld(4'd11, 0); do_wr(8'h00);
    do_ld(4'd4, 0); do_rd(0);
    chk("R8 bank0 byte0", rdata, 8'h01);
    do_ld(4'd11, 0); do_wr(8'h01);
    do_ld(4'd4, 0);
    for (int i = 0; i < 4; i++) do_rd(0);
    chk("R8 bank1 byte3", rdata, 8'hD4);
    // R6/R7 read sweep
    do_ld(4'd1, 0);
    for (int i = 1; i <= 15; i++) do_rd(0);
    chk("R2 read wrap to 0", idx, 0);
    do_ld(4'd13, 0); do_rd(0);
    chk("R7 stat1", rdata, 8'h00);
    // R10 load with simultaneous access
    do_ld(4'd2, 1);
    // R10 both strobes: write only
    do_rd(1);
    // random mix
    for (int n = 0; n < 500; n++) begin
      int op;
      op = $urandom_range(0, 9);
      stat0 = 8'($urandom); stat2 = 8'($urandom); stat3 = 8'($urandom);
      if (op < 4) do_wr(8'($urandom));
      else if (op < 7) do_rd(op == 6 && $urandom_range(0, 3) == 0);
      else if (op == 7) do_ld(4'($urandom), $urandom_range(0, 1) == 1);
      else if (op == 8) do_hdr($urandom_range(0, 1) == 1, $urandom);
      else do_ifs(8'($urandom));
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule